// File: doc/BRIEF.md
# Pixel Hit Event Frame Packer

The block packs one readout event of a pixel front-end chip into a stream of 32-bit words. A trigger beat opens the event and supplies the bunch-crossing number, the event number and four status bits. The chip address comes from a separate static input. The packer then takes pixel hits one at a time and closes the event when an end-of-hits beat arrives. The output is a header word, one word per kept hit and a trailer word, in that order. The trailer holds the number of hits framed, a 12-bit checksum over those hits and an error nibble.

Each pixel hit carries a 24-bit address, a 5-bit ADC value and a one-bit flag. A run-time limit caps the number of hits in one event. Hits beyond the limit are discarded and the trailer records the truncation. Every channel uses a valid/ready handshake. The output word is held in a single register. An event with no hits still yields a header and a trailer.

Top module: `evt_framer`

## Requirements
- R1: When a trigger beat is accepted, the next output word is the header. Its layout is bunch crossing in [31:20], event number in [19:8], `chip_addr` in [7:4] and trigger status in [3:0], and it is marked with `out_sop`=1 and `out_eop`=0.
- R2: Each kept hit is emitted as one word: bits [31:30]=0, address in [29:6], ADC in [5:1] and flag in [0]. Both `out_sop` and `out_eop` are 0, and hits keep their arrival order.
- R3: The trailer follows the last kept hit and is marked with `out_eop`=1 and `out_sop`=0. Bits [31:16] hold the number of hit words emitted in that event, and bits [3:1] are 0.
- R4: Trailer bits [15:4] hold the XOR, over all emitted hit words, of fold(h). For the 30-bit hit h, fold(h) = h[11:0] ^ h[23:12] ^ {6'b0, h[29:24]}. The value is 0 for an event with no hits.
- R5: A hit that arrives once `max_hits` hits have already been kept is dropped: it produces no output word and does not change the count or the checksum. Trailer bit [0] is 1 if and only if at least one hit in the event was dropped. With `max_hits`=0 every hit is dropped.
- R6: An end-of-hits beat (`hit_valid`=1 with `hit_end`=1) carries no hit. When it directly follows the trigger, the event is a header followed by a trailer of all zeros in [31:4].
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged. No word is lost or repeated under backpressure.
- R8: `trig_ready` is 0 from the acceptance of a trigger until the trailer handshake completes, and is 1 in the cycle after that. `hit_ready` is 1 only inside an open event.
- R9: During and right after reset, `out_valid`=0, `trig_ready`=1 and `hit_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_addr | input | 4 | Chip address placed in the header |
| max_hits | input | 16 | Largest number of hits kept per event; change only between events |
| trig_valid | input | 1 | Trigger beat present |
| trig_ready | output | 1 | Trigger accepted when high together with trig_valid |
| trig_bx | input | 12 | Bunch-crossing number |
| trig_evt | input | 12 | Event number |
| trig_status | input | 4 | Status nibble for the header |
| hit_valid | input | 1 | Hit or end-of-hits beat present |
| hit_ready | output | 1 | Hit beat accepted when high together with hit_valid |
| hit_end | input | 1 | Beat is the end-of-hits marker, with no hit data |
| hit_addr | input | 24 | Pixel address |
| hit_adc | input | 5 | Pixel charge |
| hit_flag | input | 1 | Pixel flag bit |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Word is a header |
| out_eop | output | 1 | Word is a trailer |

## Verification
A stale hit counter or checksum stays hidden until the trailer of its event leaves, so each event is closed and drained before the next begins. This exposes it within one event. A wrong state register shows up sooner: a stuck open event holds `trig_ready` low and is caught on the first cycle after the trailer handshake. A lost, repeated or mutated word under backpressure shows up in the very next output word compared against the model's queue. A comparison against the held word also runs on every stalled cycle.

// File: rtl/evt_framer.sv
module evt_framer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  chip_addr,
  input  logic [15:0] max_hits,
  input  logic        trig_valid,
  output logic        trig_ready,
  input  logic [11:0] trig_bx,
  input  logic [11:0] trig_evt,
  input  logic [3:0]  trig_status,
  input  logic        hit_valid,
  output logic        hit_ready,
  input  logic        hit_end,
  input  logic [23:0] hit_addr,
  input  logic [4:0]  hit_adc,
  input  logic        hit_flag,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sop,
  output logic        out_eop
);
  typedef enum logic [1:0] {S_IDLE, S_HITS, S_TRL} st_t;
  st_t st;

  logic [15:0] cnt;
  logic [11:0] csum;
  logic        trunc;

  wire        slot  = !out_valid || out_ready;
  wire [29:0] hw    = {hit_addr, hit_adc, hit_flag};
  wire [11:0] hfold = hw[11:0] ^ hw[23:12] ^ {6'd0, hw[29:24]};
  wire        keep  = cnt < max_hits;

  assign trig_ready = (st == S_IDLE);
  assign hit_ready  = (st == S_HITS) && slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      cnt       <= '0;
      csum      <= '0;
      trunc     <= 1'b0;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      case (st)
        S_IDLE: if (trig_valid) begin
          out_valid <= 1'b1;
          out_data  <= {trig_bx, trig_evt, chip_addr, trig_status};
          out_sop   <= 1'b1;
          out_eop   <= 1'b0;
          cnt       <= '0;
          csum      <= '0;
          trunc     <= 1'b0;
          st        <= S_HITS;
        end
        S_HITS: if (hit_valid && slot) begin
          if (hit_end) begin
            out_valid <= 1'b1;
            out_data  <= {cnt, csum, 3'b000, trunc};
            out_sop   <= 1'b0;
            out_eop   <= 1'b1;
            st        <= S_TRL;
          end else if (keep) begin
            out_valid <= 1'b1;
            out_data  <= {2'b00, hw};
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            cnt       <= cnt + 16'd1;
            csum      <= csum ^ hfold;
          end else begin
            trunc     <= 1'b1;
          end
        end
        S_TRL: if (out_valid && out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_framer_chk.sv
module evt_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] max_hits,
  input logic        trig_valid,
  input logic        trig_ready,
  input logic        hit_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_sop,
  input logic        out_eop
);
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready |=> out_valid && out_sop && !out_eop); // R1
  AST_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> out_data[3:1] == 3'b000); // R3
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> out_data[31:16] <= max_hits); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !trig_ready); // R8
  AST_HIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |-> !trig_ready); // R8
  AST_EOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> trig_ready); // R8
endmodule

bind evt_framer evt_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .max_hits(max_hits), .trig_valid(trig_valid),
  .trig_ready(trig_ready), .hit_ready(hit_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/sim_evt_framer.sv
`timescale 1ns/1ps
module sim_evt_framer;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  chip_addr;
  logic [15:0] max_hits;
  logic        trig_valid, trig_ready;
  logic [11:0] trig_bx, trig_evt;
  logic [3:0]  trig_status;
  logic        hit_valid, hit_ready, hit_end;
  logic [23:0] hit_addr;
  logic [4:0]  hit_adc;
  logic        hit_flag;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [31:0] out_data;

  evt_framer u0 (.*);

  int nchk = 0, nfail = 0;
  logic [31:0] expq[$];
  int          kindq[$];
  bit run = 0, in_event = 0, stall_prev = 0, heavy = 0, done = 0;
  logic [31:0] held;
  logic [7:0]  lfsr = 8'hA5;

  task automatic fail(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nfail++;
    $display("FAIL %s: got %h expected %h", tag, got, exp);
  endtask

  function automatic logic [11:0] fold(input logic [29:0] h);
    return h[11:0] ^ h[23:12] ^ {6'd0, h[29:24]};
  endfunction

  always @(negedge clk) if (run) begin
    if (stall_prev) begin
      nchk++;
      if (!out_valid || out_data !== held) fail("R7 hold", out_data, held);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = heavy ? (&lfsr[1:0]) : (|lfsr[1:0]);
    if (out_valid && out_ready) begin
      nchk++;
      if (expq.size() == 0) fail("R7 extra word", out_data, 32'h0);
      else begin
        automatic logic [31:0] e = expq.pop_front();
        automatic int k = kindq.pop_front();
        if (out_data !== e || out_sop !== (k == 0) || out_eop !== (k == 2))
          case (k)
            0: fail("R1 header", out_data, e);
            1: fail("R2 hit", out_data, e);
            default: fail("R3 R4 R5 R6 trailer", out_data, e);
          endcase
        if (k == 2) in_event = 0;
      end
    end
    stall_prev = out_valid && !out_ready;
    held = out_data;
    if (in_event) begin
      nchk++;
      if (trig_ready) fail("R8 trig_ready during event", {31'd0, trig_ready}, 32'd0);
    end
  end

  task automatic send_hit(input bit last, input logic [29:0] h);
    hit_valid = 1; hit_end = last;
    {hit_addr, hit_adc, hit_flag} = h;
    forever begin
      #1;
      if (hit_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    hit_valid = 0; hit_end = 0;
  endtask

  task automatic run_event(input logic [11:0] bx, input logic [11:0] ev,
                           input logic [3:0] sts, input int n, input int mx);
    logic [11:0] cs = 0;
    int kept = 0;
    max_hits = mx[15:0];
    expq.push_back({bx, ev, chip_addr, sts}); kindq.push_back(0);
    for (int i = 0; i < n; i++) begin
      automatic logic [29:0] h = {24'(i * 40503 + ev * 977), 5'(i * 7 + ev), 1'(i)};
      if (kept < mx) begin
        expq.push_back({2'b00, h}); kindq.push_back(1);
        cs ^= fold(h); kept++;
      end
    end
    expq.push_back({16'(kept), cs, 3'b000, 1'(n > mx)}); kindq.push_back(2);
    trig_valid = 1; trig_bx = bx; trig_evt = ev; trig_status = sts;
    forever begin
      #1;
      if (trig_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    trig_valid = 0;
    in_event = 1;
    for (int i = 0; i < n; i++) begin
      send_hit(0, {24'(i * 40503 + ev * 977), 5'(i * 7 + ev), 1'(i)});
      if (i % 3 == 2) @(negedge clk);
    end
    send_hit(1, 30'h0);
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    nchk++;
    if (!trig_ready) fail("R8 trig_ready after trailer", {31'd0, trig_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 0; chip_addr = 4'hB; max_hits = 16'd8;
    trig_valid = 0; trig_bx = 0; trig_evt = 0; trig_status = 0;
    hit_valid = 0; hit_end = 0; hit_addr = 0; hit_adc = 0; hit_flag = 0;
    out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;
    if (out_valid !== 0 || trig_ready !== 1 || hit_ready !== 0)
      fail("R9 reset", {29'd0, out_valid, trig_ready, hit_ready}, 32'd2);
    rst_n = 1;
    run = 1;
    @(negedge clk);
    run_event(12'h123, 12'h001, 4'h5, 3, 8);     // R1 R2 R3 R4
    run_event(12'hFFF, 12'h002, 4'hA, 0, 8);     // R6 zero hits
    run_event(12'h010, 12'h003, 4'h0, 5, 2);     // R5 truncation
    run_event(12'h020, 12'h004, 4'h1, 4, 4);     // R5 exact limit, no flag
    run_event(12'h030, 12'h005, 4'h2, 3, 0);     // R5 limit zero
    heavy = 1;
    run_event(12'h040, 12'hABC, 4'hF, 20, 30);   // R7 heavy backpressure
    run_event(12'h050, 12'h007, 4'h3, 12, 9);    // R5 R7 truncation under stall
    heavy = 0;
    run_event(12'h060, 12'h008, 4'h4, 0, 0);     // R6 zero hits, zero limit
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule